// File: doc/BRIEF.md
# Freezable Instruction Cache

This block sits between the fetch port of a four-stage instruction pipeline (fetch, decode, read, execute) and external program memory. It is a small fully associative cache of single-word lines. Each line holds an instruction word, its address tag and a valid flag. A fetch that hits returns the stored word without touching memory. A fetch that misses stalls until memory answers through a valid/ready handshake, and the returned word may then be placed in a line.

Three control bits steer the cache: enable, freeze and clear. With enable low the cache is bypassed, and every fetch goes to memory. With enable high and freeze low, hits are served and misses fill lines, with least-recently-used replacement. With both bits high, hits are still served, but no line is ever filled or replaced. Setting clear invalidates every line in a single cycle, and the clear bit then drops by itself.

Control writes come from the execute stage. Instructions fetched behind the writing instruction are already in the pipeline, so a write only takes hold after a fixed number of further fetches have completed. That number is one value for enable and freeze and another for clear.

Top module: `icache_frz`

## Requirements
- R1: After reset, `mode_en`, `mode_frz`, `clr_pend`, `f_ack` and `mem_valid` are 0 and no line is valid.
- R2: While the active enable is 0, every fetch is answered from memory with `f_hit`=0 and no line is allocated, whatever the freeze bit holds.
- R3: While enabled and not frozen, a fetch whose address is cached is answered with `f_hit`=1 and the stored word, with no memory request. A miss is answered with `f_hit`=0 and the memory word, and it allocates a line.
- R4: While enabled and frozen, hits are served as in R3 and refresh recency. A miss is answered from memory but leaves every line unchanged.
- R5: A fill goes to an invalid line if one exists. Otherwise it evicts the line least recently hit or filled while enabled.
- R6: A control write (`ctl_wr`) loads enable and freeze into a pending copy. The next MODE_LAG completed fetches still use the old mode, and every later fetch uses the new one. `mode_en`/`mode_frz` show the active mode. A new write restarts the count.
- R7: A control write with `ctl_clr`=1 sets `clr_pend`. The next CLR_LAG completed fetches still see the old contents. Then all lines become invalid and `clr_pend` returns to 0 in the same cycle.
- R8: On a miss, `mem_valid` stays high with a stable `mem_addr` (the fetch address) until `mem_ready` is sampled high with `mem_rdata`. No `f_ack` is given before that.
- R9: `f_ack` is a one-cycle pulse carrying `f_data` and `f_hit`. The requester holds `f_req` and `f_addr` until it sees `f_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| f_req | input | 1 | Fetch request |
| f_addr | input | AW | Fetch address |
| f_ack | output | 1 | Fetch done pulse |
| f_data | output | DW | Fetched instruction word |
| f_hit | output | 1 | Word came from the cache |
| mem_valid | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read address |
| mem_ready | input | 1 | Memory read data valid |
| mem_rdata | input | DW | Memory read data |
| ctl_wr | input | 1 | Control write from execute stage |
| ctl_en | input | 1 | New enable value |
| ctl_frz | input | 1 | New freeze value |
| ctl_clr | input | 1 | Request invalidation of all lines |
| mode_en | output | 1 | Active enable |
| mode_frz | output | 1 | Active freeze |
| clr_pend | output | 1 | Clear requested, not yet done |

## Verification
The bench builds the cache with LINES=8 and keeps the default lags of 4 and 5. Eight lines let a pool of fourteen addresses overflow the cache. That brings least-recently-used eviction, fills after a clear and frozen misses on a full cache within a few hundred fetches. The bench changes memory contents between fetches, so a served hit is told apart from a memory access by its stale word.

// File: rtl/icache_frz.sv
module icache_frz #(
  parameter int LINES    = 64,
  parameter int AW       = 24,
  parameter int DW       = 32,
  parameter int MODE_LAG = 4,
  parameter int CLR_LAG  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          f_req,
  input  logic [AW-1:0] f_addr,
  output logic          f_ack,
  output logic [DW-1:0] f_data,
  output logic          f_hit,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  input  logic          ctl_wr,
  input  logic          ctl_en,
  input  logic          ctl_frz,
  input  logic          ctl_clr,
  output logic          mode_en,
  output logic          mode_frz,
  output logic          clr_pend
);
  localparam int IW  = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int MCW = $clog2(MODE_LAG + 1);
  localparam int CCW = $clog2(CLR_LAG + 1);

  typedef enum logic [1:0] {S_IDLE, S_MISS, S_RESP} st_t;
  st_t st_q;

  logic [AW-1:0]    tag_q [LINES];
  logic [DW-1:0]    dat_q [LINES];
  logic [IW-1:0]    age_q [LINES];
  logic [LINES-1:0] val_q;
  logic [LINES-1:0] hit_vec;
  logic [AW-1:0]    a_q;
  logic             fm_en, fm_frz;
  logic             pend_en, pend_frz;
  logic [MCW-1:0]   mcnt;
  logic [CCW-1:0]   ccnt;

  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_cmp
      assign hit_vec[g] = val_q[g] && (tag_q[g] == f_addr);
    end
  endgenerate

  logic [IW-1:0] hit_idx, vic_idx, touch_idx, touch_age;
  logic          vic_found;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < LINES; i++)
      if (hit_vec[i]) hit_idx = IW'(i);
  end

  always_comb begin
    vic_idx   = '0;
    vic_found = 1'b0;
    for (int i = LINES - 1; i >= 0; i--)
      if (!val_q[i]) begin
        vic_idx   = IW'(i);
        vic_found = 1'b1;
      end
    if (!vic_found)
      for (int i = 0; i < LINES; i++)
        if (age_q[i] == IW'(LINES - 1)) vic_idx = IW'(i);
  end

  wire accept   = (st_q == S_IDLE) && f_req;
  wire look_hit = accept && mode_en && (|hit_vec);
  wire mem_done = (st_q == S_MISS) && mem_ready;
  wire alloc    = mem_done && fm_en && !fm_frz;
  wire touch_en = look_hit || alloc;
  wire clr_req  = ctl_wr && ctl_clr;
  wire clr_fire = f_ack && (ccnt == CCW'(1)) && !clr_req;

  assign touch_idx = look_hit ? hit_idx : vic_idx;
  assign touch_age = age_q[touch_idx];
  assign f_ack     = (st_q == S_RESP);
  assign mem_valid = (st_q == S_MISS);
  assign mem_addr  = a_q;
  assign clr_pend  = (ccnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      a_q    <= '0;
      fm_en  <= 1'b0;
      fm_frz <= 1'b0;
      f_data <= '0;
      f_hit  <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (f_req) begin
          a_q    <= f_addr;
          fm_en  <= mode_en;
          fm_frz <= mode_frz;
          if (look_hit) begin
            f_data <= dat_q[hit_idx];
            f_hit  <= 1'b1;
            st_q   <= S_RESP;
          end else begin
            st_q <= S_MISS;
          end
        end
        S_MISS: if (mem_ready) begin
          f_data <= mem_rdata;
          f_hit  <= 1'b0;
          st_q   <= S_RESP;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q <= '0;
      for (int i = 0; i < LINES; i++) begin
        tag_q[i] <= '0;
        dat_q[i] <= '0;
        age_q[i] <= IW'(i);
      end
    end else begin
      if (clr_fire) val_q <= '0;
      else if (alloc) begin
        val_q[vic_idx] <= 1'b1;
        tag_q[vic_idx] <= a_q;
        dat_q[vic_idx] <= mem_rdata;
      end
      if (touch_en)
        for (int i = 0; i < LINES; i++)
          if (IW'(i) == touch_idx) age_q[i] <= '0;
          else if (age_q[i] < touch_age) age_q[i] <= age_q[i] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_en  <= 1'b0;
      mode_frz <= 1'b0;
      pend_en  <= 1'b0;
      pend_frz <= 1'b0;
      mcnt     <= '0;
      ccnt     <= '0;
    end else begin
      if (ctl_wr) begin
        pend_en  <= ctl_en;
        pend_frz <= ctl_frz;
        mcnt     <= MCW'(MODE_LAG);
      end else if (f_ack && mcnt != '0) begin
        mcnt <= mcnt - 1'b1;
        if (mcnt == MCW'(1)) begin
          mode_en  <= pend_en;
          mode_frz <= pend_frz;
        end
      end
      if (clr_req) ccnt <= CCW'(CLR_LAG);
      else if (f_ack && ccnt != '0) ccnt <= ccnt - 1'b1;
    end
  end

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)); // R8
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    f_ack |=> !f_ack); // R9
  AST_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_MISS) && !(fm_en && !fm_frz) |=> $stable(val_q)); // R4
  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    f_ack && !fm_en |-> !f_hit); // R2
  AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    f_ack && f_hit |-> !$past(mem_valid)); // R3
  AST_CLR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clr_pend) |-> val_q == '0); // R7
  AST_MODE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({mode_en, mode_frz}) |-> $past(f_ack)); // R6
endmodule

// File: tb/icache_frz_tb.sv
module icache_frz_tb_top;
  localparam int LINES = 8, AW = 24, DW = 32, MLAG = 4, CLAG = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic f_req = 1'b0, ctl_wr = 1'b0, ctl_en = 1'b0, ctl_frz = 1'b0, ctl_clr = 1'b0;
  logic [AW-1:0] f_addr = '0;
  logic f_ack, f_hit, mem_valid, mode_en, mode_frz, clr_pend;
  logic [DW-1:0] f_data, mem_rdata = '0;
  logic [AW-1:0] mem_addr;
  logic mem_ready = 1'b0;

  always #10 clk = ~clk;

  icache_frz #(.LINES(LINES), .AW(AW), .DW(DW), .MODE_LAG(MLAG), .CLR_LAG(CLAG)) dut_i (
    .clk(clk), .rst_n(rst_n), .f_req(f_req), .f_addr(f_addr), .f_ack(f_ack),
    .f_data(f_data), .f_hit(f_hit), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .ctl_wr(ctl_wr), .ctl_en(ctl_en),
    .ctl_frz(ctl_frz), .ctl_clr(ctl_clr), .mode_en(mode_en), .mode_frz(mode_frz),
    .clr_pend(clr_pend));

  int checks = 0, fails = 0, ver = 0, tick = 0, mw = 0;
  bit m_val [LINES];
  logic [AW-1:0] m_tag [LINES];
  logic [DW-1:0] m_dat [LINES];
  int m_use [LINES];
  bit m_en = 0, m_frz = 0, p_en = 0, p_frz = 0;
  int mcnt = 0, ccnt = 0;
  bit pv = 0, pr = 0;
  logic [AW-1:0] pa = '0;

  function automatic logic [DW-1:0] mem_fn(input logic [AW-1:0] a, input int v);
    return (DW'(a) * 32'h9E3779B1) ^ (DW'(v) * 32'h01000193);
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 1'b0; pv = 0; pr = 0;
    end else begin
      if (mem_valid && pv && !pr)
        check(mem_addr == pa, "R8", "mem_addr held", 64'(mem_addr), 64'(pa));
      pv = mem_valid; pr = mem_ready; pa = mem_addr;
      if (mem_valid && !mem_ready) begin
        if (mw == 0) begin
          mem_ready = 1'b1;
          mem_rdata = mem_fn(mem_addr, ver);
          mw = int'($urandom % 4);
        end else mw--;
      end else mem_ready = 1'b0;
    end
  end

  task automatic fetch(input logic [AW-1:0] a, input string rq_in);
    int idx = -1, n = 0, vic = -1;
    bit exp_hit, saw_mem = 0;
    logic [DW-1:0] exp_dat;
    string rq;
    rq = (rq_in != "") ? rq_in : (!m_en ? "R2" : (m_frz ? "R4" : "R3"));
    if (m_en) for (int i = 0; i < LINES; i++) if (m_val[i] && m_tag[i] == a) idx = i;
    exp_hit = (idx >= 0);
    exp_dat = exp_hit ? m_dat[idx] : mem_fn(a, ver);
    @(negedge clk);
    f_req = 1'b1; f_addr = a;
    do begin
      @(negedge clk);
      n++;
      if (mem_valid) saw_mem = 1;
    end while (!f_ack && n < 60);
    check(f_ack == 1'b1, "R8", "fetch completed", 64'(f_ack), 64'd1);
    check(f_hit == exp_hit, rq, "f_hit", 64'(f_hit), 64'(exp_hit));
    check(f_data == exp_dat, rq, "f_data", 64'(f_data), 64'(exp_dat));
    check(saw_mem == !exp_hit, "R9", "memory used only on miss", 64'(saw_mem), 64'(!exp_hit));
    f_req = 1'b0;
    @(negedge clk);
    check(f_ack == 1'b0, "R9", "ack one cycle", 64'(f_ack), 64'd0);
    if (exp_hit) m_use[idx] = tick++;
    else if (m_en && !m_frz) begin
      for (int i = LINES - 1; i >= 0; i--) if (!m_val[i]) vic = i;
      if (vic < 0) begin
        vic = 0;
        for (int i = 1; i < LINES; i++) if (m_use[i] < m_use[vic]) vic = i;
      end
      m_val[vic] = 1; m_tag[vic] = a; m_dat[vic] = exp_dat; m_use[vic] = tick++;
    end
    if (mcnt > 0) begin
      mcnt--;
      if (mcnt == 0) begin m_en = p_en; m_frz = p_frz; end
    end
    if (ccnt > 0) begin
      ccnt--;
      if (ccnt == 0) for (int i = 0; i < LINES; i++) m_val[i] = 0;
    end
  endtask

  task automatic ctl(input bit en, input bit frz, input bit clr);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_en = en; ctl_frz = frz; ctl_clr = clr;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_clr = 1'b0;
    p_en = en; p_frz = frz; mcnt = MLAG;
    if (clr) ccnt = CLAG;
    check(mode_en == m_en && mode_frz == m_frz, "R6", "mode held after write",
          64'({mode_en, mode_frz}), 64'({m_en, m_frz}));
    check(clr_pend == (ccnt != 0), "R7", "clr_pend", 64'(clr_pend), 64'(ccnt != 0));
  endtask

  initial begin
    #(20 * 150000);
    check(1'b0, "R8", "watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < LINES; i++) begin m_val[i] = 0; m_use[i] = -i; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!f_ack && !mem_valid && !mode_en && !mode_frz && !clr_pend, "R1", "reset outputs",
          64'({f_ack, mem_valid, mode_en, mode_frz, clr_pend}), 64'd0);

    fetch(24'h100, "R2");
    fetch(24'h100, "R2");
    ctl(1, 0, 0);
    for (int k = 0; k < MLAG; k++) begin
      check(mode_en == 1'b0, "R6", "old mode during lag", 64'(mode_en), 64'd0);
      fetch(24'h100, "R6");
    end
    check(mode_en == 1'b1, "R6", "new mode after lag", 64'(mode_en), 64'd1);

    for (int k = 0; k < LINES; k++) fetch(24'h100 + AW'(k), "R3");
    ver++;
    fetch(24'h100, "R3");
    fetch(24'h100 + AW'(LINES), "R5");
    fetch(24'h101, "R5");
    fetch(24'h100, "R5");

    ctl(1, 1, 0);
    for (int k = 0; k < MLAG; k++) fetch(24'h100 + AW'(k), "");
    ver++;
    fetch(24'h200, "R4");
    fetch(24'h200, "R4");
    for (int k = 0; k < LINES + 2; k++) fetch(24'h100 + AW'(k), "R4");

    ctl(1, 0, 1);
    for (int k = 0; k < CLAG; k++) begin
      check(clr_pend == 1'b1, "R7", "clear pending", 64'(clr_pend), 64'd1);
      fetch(24'h100 + AW'(k), "R7");
    end
    check(clr_pend == 1'b0, "R7", "clear self-drops", 64'(clr_pend), 64'd0);
    fetch(24'h100, "R7");
    fetch(24'h100, "R7");

    ctl(0, 1, 0);
    for (int k = 0; k < MLAG + 3; k++) fetch(24'h100 + AW'(k % 3), "");

    for (int k = 0; k < 500; k++) begin
      if ($urandom % 16 == 0)
        ctl(($urandom % 4) != 0, ($urandom % 3) == 0, ($urandom % 4) == 0);
      if ($urandom % 10 == 0) ver++;
      fetch(24'h300 + AW'($urandom % 14), "");
    end
    finish_run();
  end
endmodule